// File: doc/BRIEF.md
# Clock Controller Register Bank

This block holds the configuration and status words of a clock control unit behind a simple synchronous bus. A bus master reaches 26 word-wide registers inside a 4 KiB window. Each register loads its own fixed value at reset. Writable registers keep only the bits their own write mask lets through. Registers without a write path keep their reset value for good. The block computes no frequencies, runs no PLL and gates no clock. It stores words, returns them on reads, and puts every stored word on a wide output bus. Other logic decodes that bus.

One access is made per cycle by raising `busWrEn`, `busRdEn` or both, with a byte address and a size code. Read data and the error flag are registered, so they appear in the cycle after the strobe. Any access the bank cannot honour changes no state and raises `busErr` for one cycle. That covers a wrong size, a misaligned address, a read past the last register and a write to a register without a write path.

Top module: `clkctl_regbank`

## Requirements
- R1: After reset each register holds its reset word. By index these are: 0 = 0x074B0B7D, 1 = 0xFF870B48, 2 = 0x49FCFE7F, 3 = 0x007F0000, 4 = 0x04001800, 5 = 0x04051C03, 6 = 0x04043001, 7 = 0x00000280, 8 to 11 = 0xFFFFFFFF, 19 = 0x00004040, 23 = 0x80209828, 24 = 0x00AA0000, 25 = 0x00000285. Indices 12 to 18 and 20 to 22 hold zero.
- R2: The register index is `busAddr[11:2]`. Indices 0 to 25 are implemented.
- R3: An access is legal only when `busSize` is 2'b10 (word) and `busAddr[1:0]` is 0. Size codes 2'b00 (byte), 2'b01 (half) and 2'b11 are illegal. An illegal access changes no register, reads back zero, and sets `busErr` in the following cycle.
- R4: A read of an index of 26 or more returns zero, with `busErr` high in the following cycle.
- R5: A write to index 0 stores the data ANDed with 0x3B6FDFFF, and bit 1 is then forced to one whatever the data.
- R6: Writes are masked as follows: index 1 with 0xFF9F3FFF, and indices 4 and 6 each with 0xBFFF3FFF.
- R7: Indices 2, 8, 9 and 10 store all 32 written bits.
- R8: A write to any other index is discarded and sets `busErr` in the following cycle. This covers indices 3, 5, 7, 11 to 25 and indices past the bank.
- R9: Read data appears one clock after the read strobe. A read and a write in the same cycle to the same index return the value held before the write.
- R10: `busRegs[32*i+31:32*i]` always shows the stored word of index i. A write shows there from the cycle after the write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 12 | Byte address within the window |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| busWrData | input | 32 | Write data |
| busSize | input | 2 | Access size code (2'b10 = word) |
| busRdData | output | 32 | Registered read data |
| busErr | output | 1 | Registered error flag for the previous access |
| busRegs | output | 832 | All stored words, index 0 in the low bits |

## Verification
A write and a read can fall in the same cycle, and when both target one index the read must return the old word while the write still takes effect. The bench drives both strobes together on a full-width gating register. It checks that the returned word is the prior value, then reads again and checks that the new word arrived on both the read port and the wide output bus. Error flagging also coincides with read data: a bad read must return zero in the very cycle its error flag rises, and this is judged on the same sample.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 12;
  localparam int NUM_REGS  = 26;
  localparam int IDX_W     = $clog2(NUM_REGS);
  localparam int WORD_IDX_W = ADDR_W - 2;
  localparam logic [1:0] SIZE_WORD = 2'b10;

  // Strobes from control to datapath.
  typedef struct packed {
    logic             wrStb;
    logic             rdStb;
    logic             errStb;
    logic [IDX_W-1:0] idx;
  } strobe_t;

  function automatic logic [DATA_W-1:0] regReset(input int i);
    case (i)
      0:  return 32'h074B0B7D;
      1:  return 32'hFF870B48;
      2:  return 32'h49FCFE7F;
      3:  return 32'h007F0000;
      4:  return 32'h04001800;
      5:  return 32'h04051C03;
      6:  return 32'h04043001;
      7:  return 32'h00000280;
      8, 9, 10, 11: return 32'hFFFFFFFF;
      19: return 32'h00004040;
      23: return 32'h80209828;
      24: return 32'h00AA0000;
      25: return 32'h00000285;
      default: return '0;
    endcase
  endfunction

  function automatic logic regWritable(input int i);
    case (i)
      0, 1, 2, 4, 6, 8, 9, 10: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] regMask(input int i);
    case (i)
      0:    return 32'h3B6FDFFF;
      1:    return 32'hFF9F3FFF;
      4, 6: return 32'hBFFF3FFF;
      2, 8, 9, 10: return 32'hFFFFFFFF;
      default: return '0;
    endcase
  endfunction

  // Bits forced high on every write (multiplier select, bit 1 of index 0).
  function automatic logic [DATA_W-1:0] regForce(input int i);
    return (i == 0) ? 32'h00000002 : '0;
  endfunction

endpackage

// File: rtl/clkctl_ctrl.sv
module clkctl_ctrl
  import clkctl_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [1:0]        busSize,
  output strobe_t           stb
);

  logic [WORD_IDX_W-1:0] wordIdx;
  logic                  aligned;
  logic                  inRange;
  logic                  canWrite;

  assign wordIdx = busAddr[ADDR_W-1:2];
  assign aligned = (busAddr[1:0] == 2'b00) && (busSize == SIZE_WORD);
  assign inRange = (wordIdx < WORD_IDX_W'(NUM_REGS));

  always_comb begin
    canWrite = 1'b0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (wordIdx == WORD_IDX_W'(i)) canWrite = regWritable(i);
    end
  end

  always_comb begin
    stb.idx    = wordIdx[IDX_W-1:0];
    stb.wrStb  = busWrEn && aligned && canWrite;
    stb.rdStb  = busRdEn && aligned && inRange;
    stb.errStb = (busWrEn && !(aligned && canWrite)) ||
                 (busRdEn && !(aligned && inRange));
  end

endmodule

// File: rtl/clkctl_data.sv
module clkctl_data
  import clkctl_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  strobe_t                    stb,
  input  logic [DATA_W-1:0]          wrData,
  output logic [DATA_W-1:0]          rdData,
  output logic                       errFlag,
  output logic [NUM_REGS*DATA_W-1:0] regFlat
);

  logic [DATA_W-1:0] regQ [NUM_REGS];
  logic [DATA_W-1:0] rdMux;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    if (regWritable(i)) begin : g_rw
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk) begin
        if (!rstN)
          q <= regReset(i);
        else if (stb.wrStb && (stb.idx == IDX_W'(i)))
          q <= (wrData & regMask(i)) | regForce(i);
      end
      assign regQ[i] = q;
    end else begin : g_ro
      assign regQ[i] = regReset(i);
    end
    assign regFlat[i*DATA_W +: DATA_W] = regQ[i];
  end

  always_comb begin
    rdMux = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (stb.idx == IDX_W'(i)) rdMux = regQ[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      errFlag <= 1'b0;
    end else begin
      rdData  <= stb.rdStb ? rdMux : '0;
      errFlag <= stb.errStb;
    end
  end

endmodule

// File: rtl/clkctl_regbank.sv
module clkctl_regbank
  import clkctl_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [ADDR_W-1:0]          busAddr,
  input  logic                       busWrEn,
  input  logic                       busRdEn,
  input  logic [DATA_W-1:0]          busWrData,
  input  logic [1:0]                 busSize,
  output logic [DATA_W-1:0]          busRdData,
  output logic                       busErr,
  output logic [NUM_REGS*DATA_W-1:0] busRegs
);

  strobe_t stb;

  clkctl_ctrl ctrl_i (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .busSize (busSize),
    .stb     (stb)
  );

  clkctl_data data_i (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .wrData  (busWrData),
    .rdData  (busRdData),
    .errFlag (busErr),
    .regFlat (busRegs)
  );

endmodule

// File: rtl/clkctl_regbank_chk.sv
module clkctl_regbank_chk
  import clkctl_pkg::*;
(
  input logic                       clk,
  input logic                       rstN,
  input logic [ADDR_W-1:0]          busAddr,
  input logic                       busWrEn,
  input logic                       busRdEn,
  input logic [DATA_W-1:0]          busWrData,
  input logic [1:0]                 busSize,
  input logic [DATA_W-1:0]          busRdData,
  input logic                       busErr,
  input logic [NUM_REGS*DATA_W-1:0] busRegs
);

  logic              legalShape;
  logic              legalRead;
  logic [DATA_W-1:0] curVal;

  assign legalShape = (busSize == SIZE_WORD) && (busAddr[1:0] == 2'b00);
  assign legalRead  = busRdEn && legalShape &&
                      (busAddr[ADDR_W-1:2] < WORD_IDX_W'(NUM_REGS));

  always_comb begin
    curVal = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (busAddr[ADDR_W-1:2] == WORD_IDX_W'(i)) curVal = busRegs[i*DATA_W +: DATA_W];
    end
  end

  a_r3_bad_shape_err: assert property (@(posedge clk) disable iff (!rstN)
    ((busWrEn || busRdEn) && !legalShape) |=> busErr);

  a_r3_bad_shape_nochange: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && !legalShape) |=> $stable(busRegs));

  a_r4_oob_read: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && legalShape && busAddr[ADDR_W-1:2] >= WORD_IDX_W'(NUM_REGS))
      |=> (busErr && busRdData == '0));

  a_r5_force_bit: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && legalShape && busAddr[ADDR_W-1:2] == '0) |=> busRegs[1]);

  a_r8_status_fixed: assert property (@(posedge clk) disable iff (!rstN)
    $stable(busRegs[3*DATA_W +: DATA_W]));

  a_r9_read_old: assert property (@(posedge clk) disable iff (!rstN)
    legalRead |=> (busRdData == $past(curVal) && !busErr));

endmodule

bind clkctl_regbank clkctl_regbank_chk chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busWrEn   (busWrEn),
  .busRdEn   (busRdEn),
  .busWrData (busWrData),
  .busSize   (busSize),
  .busRdData (busRdData),
  .busErr    (busErr),
  .busRegs   (busRegs)
);

// File: tb/clkctl_regbank_tb_top.sv
`timescale 1ns/1ps
module clkctl_regbank_tb_top;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [11:0]  busAddr = '0;
  logic         busWrEn = 1'b0;
  logic         busRdEn = 1'b0;
  logic [31:0]  busWrData = '0;
  logic [1:0]   busSize = 2'b10;
  logic [31:0]  busRdData;
  logic         busErr;
  logic [831:0] busRegs;

  int nChecks = 0;
  int nFail = 0;

  always #10 clk = ~clk;

  clkctl_regbank dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .busSize(busSize),
    .busRdData(busRdData), .busErr(busErr), .busRegs(busRegs)
  );

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [1:0]  sz;
    logic [31:0] wd;
    logic [31:0] exp;
    logic        err;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 35;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 12'h000, 2'd2, 32'hFFFFFFFF, 32'h0,        1'b0, 4'd5}, // R5
    '{1'b0, 12'h000, 2'd2, 32'h0,        32'h3B6FDFFF, 1'b0, 4'd5},
    '{1'b1, 12'h000, 2'd2, 32'h0,        32'h0,        1'b0, 4'd5},
    '{1'b0, 12'h000, 2'd2, 32'h0,        32'h00000002, 1'b0, 4'd5},
    '{1'b1, 12'h004, 2'd2, 32'hFFFFFFFF, 32'h0,        1'b0, 4'd6}, // R6
    '{1'b0, 12'h004, 2'd2, 32'h0,        32'hFF9F3FFF, 1'b0, 4'd6},
    '{1'b1, 12'h010, 2'd2, 32'hFFFFFFFF, 32'h0,        1'b0, 4'd6},
    '{1'b0, 12'h010, 2'd2, 32'h0,        32'hBFFF3FFF, 1'b0, 4'd6},
    '{1'b1, 12'h018, 2'd2, 32'hA5A5A5A5, 32'h0,        1'b0, 4'd6},
    '{1'b0, 12'h018, 2'd2, 32'h0,        32'hA5A525A5, 1'b0, 4'd6},
    '{1'b1, 12'h008, 2'd2, 32'h12345678, 32'h0,        1'b0, 4'd7}, // R7
    '{1'b0, 12'h008, 2'd2, 32'h0,        32'h12345678, 1'b0, 4'd7},
    '{1'b1, 12'h020, 2'd2, 32'h0,        32'h0,        1'b0, 4'd7},
    '{1'b0, 12'h020, 2'd2, 32'h0,        32'h0,        1'b0, 4'd7},
    '{1'b1, 12'h028, 2'd2, 32'hDEADBEEF, 32'h0,        1'b0, 4'd7},
    '{1'b0, 12'h028, 2'd2, 32'h0,        32'hDEADBEEF, 1'b0, 4'd7},
    '{1'b1, 12'h00C, 2'd2, 32'h0,        32'h0,        1'b1, 4'd8}, // R8
    '{1'b0, 12'h00C, 2'd2, 32'h0,        32'h007F0000, 1'b0, 4'd8},
    '{1'b1, 12'h014, 2'd2, 32'h0,        32'h0,        1'b1, 4'd8},
    '{1'b0, 12'h014, 2'd2, 32'h0,        32'h04051C03, 1'b0, 4'd8},
    '{1'b1, 12'h02C, 2'd2, 32'h0,        32'h0,        1'b1, 4'd8},
    '{1'b0, 12'h02C, 2'd2, 32'h0,        32'hFFFFFFFF, 1'b0, 4'd8},
    '{1'b1, 12'h064, 2'd2, 32'h0,        32'h0,        1'b1, 4'd8},
    '{1'b0, 12'h064, 2'd2, 32'h0,        32'h00000285, 1'b0, 4'd8},
    '{1'b1, 12'h068, 2'd2, 32'h0,        32'h0,        1'b1, 4'd8},
    '{1'b0, 12'h068, 2'd2, 32'h0,        32'h0,        1'b1, 4'd4}, // R4
    '{1'b0, 12'hFFC, 2'd2, 32'h0,        32'h0,        1'b1, 4'd4},
    '{1'b1, 12'h009, 2'd2, 32'h0,        32'h0,        1'b1, 4'd3}, // R3
    '{1'b1, 12'h008, 2'd1, 32'h0,        32'h0,        1'b1, 4'd3},
    '{1'b1, 12'h008, 2'd0, 32'h0,        32'h0,        1'b1, 4'd3},
    '{1'b0, 12'h008, 2'd2, 32'h0,        32'h12345678, 1'b0, 4'd3},
    '{1'b0, 12'h00A, 2'd2, 32'h0,        32'h0,        1'b1, 4'd3},
    '{1'b0, 12'h008, 2'd1, 32'h0,        32'h0,        1'b1, 4'd3},
    '{1'b1, 12'h030, 2'd2, 32'h0,        32'h0,        1'b1, 4'd8},
    '{1'b0, 12'h030, 2'd2, 32'h0,        32'h0,        1'b0, 4'd8}
  };

  function automatic logic [31:0] expReset(input int i);
    case (i)
      0: return 32'h074B0B7D;  1: return 32'hFF870B48;
      2: return 32'h49FCFE7F;  3: return 32'h007F0000;
      4: return 32'h04001800;  5: return 32'h04051C03;
      6: return 32'h04043001;  7: return 32'h00000280;
      8, 9, 10, 11: return 32'hFFFFFFFF;
      19: return 32'h00004040; 23: return 32'h80209828;
      24: return 32'h00AA0000; 25: return 32'h00000285;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doAccess(input logic wr, input logic rd, input logic [11:0] a,
                          input logic [1:0] sz, input logic [31:0] wd,
                          output logic [31:0] rdv, output logic errv);
    @(negedge clk);
    busWrEn = wr; busRdEn = rd; busAddr = a; busSize = sz; busWrData = wd;
    @(negedge clk);
    rdv = busRdData; errv = busErr;
    busWrEn = 1'b0; busRdEn = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    nChecks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    logic [31:0] rv;
    logic        ev;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R10 and R1: wide output bus after reset
    check("R10 reset busRegs idx0", busRegs[31:0], 32'h074B0B7D);
    check("R10 reset busRegs idx25", busRegs[25*32 +: 32], 32'h00000285);
    check("R1 reset busErr", {31'b0, busErr}, 32'h0);

    // R1, R2: every reset word read at index*4
    for (int i = 0; i < 26; i++) begin
      doAccess(1'b0, 1'b1, 12'(i * 4), 2'd2, 32'h0, rv, ev);
      check($sformatf("R1 R2 reset read idx%0d", i), rv, expReset(i));
    end

    // Vector table walk
    for (int v = 0; v < NV; v++) begin
      doAccess(VECS[v].wr, !VECS[v].wr, VECS[v].addr, VECS[v].sz, VECS[v].wd, rv, ev);
      check($sformatf("R%0d vec%0d err", VECS[v].req, v), {31'b0, ev}, {31'b0, VECS[v].err});
      if (!VECS[v].wr)
        check($sformatf("R%0d vec%0d data", VECS[v].req, v), rv, VECS[v].exp);
    end

    // R9: simultaneous write and read of index 9 returns old word
    doAccess(1'b1, 1'b1, 12'h024, 2'd2, 32'h11112222, rv, ev);
    check("R9 same-cycle read old", rv, 32'hFFFFFFFF);
    check("R9 same-cycle err", {31'b0, ev}, 32'h0);
    check("R10 busRegs idx9 after write", busRegs[9*32 +: 32], 32'h11112222);
    doAccess(1'b0, 1'b1, 12'h024, 2'd2, 32'h0, rv, ev);
    check("R9 read new word", rv, 32'h11112222);

    // R5, R10: control bit 1 visible on the wide bus
    check("R10 busRegs idx0", busRegs[31:0], 32'h00000002);
    // R8: status word unchanged on the wide bus after rejected write
    check("R8 busRegs idx3", busRegs[3*32 +: 32], 32'h007F0000);
    // R3: rejected write left index 2 untouched on the wide bus
    check("R3 busRegs idx2", busRegs[2*32 +: 32], 32'h12345678);

    // R1: reset again restores words
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    doAccess(1'b0, 1'b1, 12'h000, 2'd2, 32'h0, rv, ev);
    check("R1 re-reset idx0", rv, 32'h074B0B7D);
    check("R1 re-reset idx8", busRegs[8*32 +: 32], 32'hFFFFFFFF);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule